// File: doc/BRIEF.md
# Codec Clock Bring-Up Sequencer

This controller brings up the clock tree of an external audio codec that runs as clock master. After a start request it sends three register writes, each an address byte and a data byte, to a downstream serial-bus engine. The first write powers the crystal oscillator. A timed settling wait follows. The second write powers the PLL, and a timed lock wait follows. The third write enables the master-clock output and selects its divider. Once all three writes are acknowledged, the block raises a level flag saying that the master, bit and frame clocks can be relied on.

Each write leaves on a valid/ready request channel. The sequencer raises `wr_valid` with `wr_addr`/`wr_data`. While `wr_ready` is low it holds all three unchanged, so the bus engine may stall for any number of cycles. The request is accepted on the first clock edge where valid and ready are both high. The sequencer then drops `wr_valid` and waits for a completion pulse (`wr_done` or `wr_err`) before it starts the next step or a wait. Only one write is ever outstanding.

Both wait lengths are computed from a system-clock frequency parameter and two microsecond parameters. The defaults give a 20 ms oscillator settling wait and a 40 ms PLL lock wait. The default configuration suits I2S, a 64x-sample-rate bit clock and an 11.2896 MHz reference.

Top module: `clk_bringup_seq`

## Requirements
- R1: During and after a synchronous reset, `busy`, `done`, `error`, `clocks_ready` and `wr_valid` are all low, and the sequencer is idle.
- R2: A one-cycle `start` while idle, finished (`clocks_ready` high) or failed (`error` high) begins a new sequence. `busy` rises, and `clocks_ready` and `error` clear.
- R3: The first write carries address 0x01 and data 0x40: oscillator power (bit 6) set, PLL power (bit 5) clear.
- R4: While `wr_valid` is high and `wr_ready` low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged. After acceptance `wr_valid` falls, and no further request is raised until `wr_done` arrives.
- R5: After the first write's `wr_done`, no request is raised for at least SETTLE cycles. The second write follows within three cycles of that minimum.
- R6: The second write carries address 0x01 and data 0x60. PLL power is never requested in a write before the settling wait has elapsed.
- R7: After the second write's `wr_done`, a lock wait of at least LOCK cycles passes. Then the third write carries address 0x04 and data 0x6A: output enable at bit 3, divider field bits 5:4 = 2'b10.
- R8: When the third write's `wr_done` arrives, `clocks_ready` rises and stays high, `busy` falls, and `done` pulses high for exactly one cycle.
- R9: A `wr_err` on any write moves the sequencer to a failed state. `error` is high, `busy` and `clocks_ready` are low, and no further write is requested until reset or a new `start`.
- R10: A `start` while `busy` is ignored: the running sequence keeps its three writes and its wait lengths.
- R11: A synchronous reset in the middle of a sequence returns the block to idle, and no further write is requested until a new `start`.
- R12: SETTLE = (CLK_HZ / 1e6) * SETTLE_US and LOCK = (CLK_HZ / 1e6) * LOCK_US clock cycles, with a minimum of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; aborts any sequence |
| start | input | 1 | Start request pulse |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Bus engine accepts the request |
| wr_addr | output | ADDR_W | Codec register address |
| wr_data | output | DATA_W | Codec register data |
| wr_done | input | 1 | Pulse: accepted write completed |
| wr_err | input | 1 | Pulse: accepted write failed |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes |
| error | output | 1 | Sequence stopped on a bus error |
| clocks_ready | output | 1 | Codec clocks are valid |

## Verification
The bench builds the block with CLK_HZ = 1,000,000, SETTLE_US = 20 and LOCK_US = 40, which shrinks the waits to 20 and 40 cycles. At that size, complete sequences, a stalled handshake, an error on the second write, a start during the settling wait and a reset during the lock wait all fit in a short run. The small waits also let the bench measure the exact gap between each completion pulse and the next request against the computed minimum. The default values give waits of millions of cycles; they change only the counter width, not the control path.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RESP,
    ST_DELAY,
    ST_READY,
    ST_ERR
  } seq_state_e;

  // Cycles for a wait given in microseconds, never below one.
  function automatic longint unsigned wait_cycles(input longint unsigned hz,
                                                  input longint unsigned us);
    longint unsigned c;
    c = (hz / 64'd1_000_000) * us;
    if (c == 64'd0) c = 64'd1;
    return c;
  endfunction

endpackage

// File: rtl/clkseq_wait_timer.sv
module clkseq_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire,
  output logic             running
);

  logic [CNT_W-1:0] cnt;

  assign running = (cnt != '0);
  assign expire  = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  // A wait ends once and does not re-arm by itself (R12)
  assert_expire_single_R12: assert property (@(posedge clk) disable iff (rst)
    expire && !load |=> !expire && !running);

  // A loaded nonzero wait is counting in the next cycle (R12)
  assert_load_runs_R12: assert property (@(posedge clk) disable iff (rst)
    load && (load_val != '0) |=> running);

endmodule

// File: rtl/clkseq_bus_write.sv
module clkseq_bus_write #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_done,
  input  logic              wr_err,
  output logic              resp_ok,
  output logic              resp_err
);

  logic pending;

  assign resp_err = pending & wr_err;
  assign resp_ok  = pending & wr_done & ~wr_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      pending  <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (go) begin
      wr_valid <= 1'b1;
      wr_addr  <= go_addr;
      wr_data  <= go_data;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
      pending  <= 1'b1;
    end else if (pending && (wr_done || wr_err)) begin
      pending  <= 1'b0;
    end
  end

  // Stalled request is held unchanged (R4)
  assert_hold_stall_R4: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // Accepted request drops valid (R4)
  assert_drop_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_ready |=> !wr_valid);

  // A new request only when nothing is outstanding (R4)
  assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (rst)
    go |-> !wr_valid && !pending);

endmodule

// File: rtl/clk_bringup_seq.sv
module clk_bringup_seq
  import clkseq_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 100_000_000,
  parameter longint unsigned SETTLE_US  = 20_000,
  parameter longint unsigned LOCK_US    = 40_000,
  parameter int              ADDR_W     = 8,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] PWR_REG    = 8'h01,
  parameter logic [ADDR_W-1:0] CLKOUT_REG = 8'h04,
  parameter logic [DATA_W-1:0] OSC_ON     = 8'h40,
  parameter logic [DATA_W-1:0] PLL_ON     = 8'h60,
  parameter logic [DATA_W-1:0] CLKOUT_CFG = 8'h6A,
  parameter int              PLL_BIT    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_done,
  input  logic              wr_err,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              clocks_ready
);

  localparam longint unsigned SETTLE_CYC = wait_cycles(CLK_HZ, SETTLE_US);
  localparam longint unsigned LOCK_CYC   = wait_cycles(CLK_HZ, LOCK_US);
  localparam longint unsigned MAX_CYC    = (SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC;
  localparam int              CNT_W      = $clog2(MAX_CYC + 64'd1);
  localparam int              STEP_W     = 2;
  localparam logic [STEP_W-1:0] LAST_STEP = 2'd2;

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic              start_ok;
  logic              go;
  logic [ADDR_W-1:0] step_addr;
  logic [DATA_W-1:0] step_data;
  logic              resp_ok, resp_err;
  logic              tmr_load, tmr_expire, tmr_running;
  logic [CNT_W-1:0]  tmr_val;
  logic              xtal_settled;

  assign start_ok = start && (state == ST_IDLE || state == ST_READY || state == ST_ERR);
  assign go       = (state == ST_REQ);
  assign tmr_load = (state == ST_RESP) && resp_ok && (step != LAST_STEP);
  assign tmr_val  = (step == 2'd0) ? CNT_W'(SETTLE_CYC) : CNT_W'(LOCK_CYC);

  // Ordered write table: oscillator, then PLL, then clock output
  always_comb begin
    case (step)
      2'd0:    begin step_addr = PWR_REG;    step_data = OSC_ON;     end
      2'd1:    begin step_addr = PWR_REG;    step_data = PLL_ON;     end
      default: begin step_addr = CLKOUT_REG; step_data = CLKOUT_CFG; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE, ST_READY, ST_ERR: begin
          if (start_ok) begin
            state <= ST_REQ;
            step  <= '0;
          end
        end
        ST_REQ:   state <= ST_RESP;
        ST_RESP: begin
          if (resp_err) begin
            state <= ST_ERR;
          end else if (resp_ok) begin
            if (step == LAST_STEP) begin
              state <= ST_READY;
              done  <= 1'b1;
            end else begin
              state <= ST_DELAY;
            end
          end
        end
        ST_DELAY: begin
          if (tmr_expire) begin
            state <= ST_REQ;
            step  <= step + 2'd1;
          end
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start_ok)                                    xtal_settled <= 1'b0;
    else if (state == ST_DELAY && tmr_expire && step == 2'd0) xtal_settled <= 1'b1;
  end

  assign busy         = (state == ST_REQ) || (state == ST_RESP) || (state == ST_DELAY);
  assign error        = (state == ST_ERR);
  assign clocks_ready = (state == ST_READY);

  clkseq_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire),
    .running  (tmr_running)
  );

  clkseq_bus_write #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .go_addr  (step_addr),
    .go_data  (step_data),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_done  (wr_done),
    .wr_err   (wr_err),
    .resp_ok  (resp_ok),
    .resp_err (resp_err)
  );

  // PLL power never requested before the oscillator has settled (R6)
  assert_pll_after_settle_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid && (wr_addr == PWR_REG) && wr_data[PLL_BIT] |-> xtal_settled);

  // No request leaves while a wait is counting (R5)
  assert_quiet_during_wait_R5: assert property (@(posedge clk) disable iff (rst)
    tmr_running |-> !wr_valid);

  // Ready state excludes busy and error (R8)
  assert_ready_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    clocks_ready |-> !busy && !error);

  // Completion flag is a single-cycle pulse (R8)
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && clocks_ready);

  // Failed state persists without a start and requests nothing (R9)
  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    error && !start |=> error && !wr_valid);

  // Start during a wait leaves the wait undisturbed (R10)
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    state == ST_DELAY && start && !tmr_expire |=> state == ST_DELAY);

endmodule

// File: tb/clk_bringup_seq_tb.sv
module clk_bringup_seq_tb;

  localparam int SETTLE = 20;
  localparam int LOCK   = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       wr_ready = 1'b0;
  logic       wr_done = 1'b0;
  logic       wr_err = 1'b0;
  logic       wr_valid, busy, done, error, clocks_ready;
  logic [7:0] wr_addr, wr_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // Bus-engine model state
  int rd_delay = 0;
  int err_on = -1;
  int rs = 0;
  int hcnt = 0;
  int nwr = 0;
  int hold_bad = 0;
  int done_cnt = 0;
  logic [7:0] ha, hd;
  logic [7:0] wa [0:15];
  logic [7:0] wd [0:15];
  int vc [0:15];
  int dc [0:15];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clk_bringup_seq #(
    .CLK_HZ(1_000_000), .SETTLE_US(SETTLE), .LOCK_US(LOCK)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .wr_err(wr_err),
    .busy(busy), .done(done), .error(error), .clocks_ready(clocks_ready)
  );

  // Responder: accepts after rd_delay stalled cycles, completes two cycles later
  always @(negedge clk) begin
    if (rst) begin
      rs = 0; nwr = 0; hold_bad = 0; done_cnt = 0;
      wr_ready = 1'b0; wr_done = 1'b0; wr_err = 1'b0;
    end else begin
      if (done) done_cnt = done_cnt + 1;
      case (rs)
        0: begin
          wr_done = 1'b0; wr_err = 1'b0;
          if (wr_valid) begin
            vc[nwr] = cyc; ha = wr_addr; hd = wr_data; hcnt = 0;
            if (rd_delay == 0) begin
              wr_ready = 1'b1; wa[nwr] = wr_addr; wd[nwr] = wr_data; rs = 2;
            end else rs = 1;
          end
        end
        1: begin
          if (!wr_valid || wr_addr !== ha || wr_data !== hd) hold_bad = hold_bad + 1;
          hcnt = hcnt + 1;
          if (hcnt >= rd_delay) begin
            wr_ready = 1'b1; wa[nwr] = wr_addr; wd[nwr] = wr_data; rs = 2;
          end
        end
        2: begin
          wr_ready = 1'b0; rs = 3;
          if (wr_valid) hold_bad = hold_bad + 1;
        end
        3: begin
          if (wr_valid) hold_bad = hold_bad + 1;
          rs = 4;
        end
        4: begin
          if (err_on == nwr) wr_err = 1'b1;
          else begin wr_done = 1'b1; dc[nwr] = cyc; end
          nwr = nwr + 1; rs = 5;
        end
        default: begin
          wr_done = 1'b0; wr_err = 1'b0; rs = 0;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (clocks_ready || error) break;
    end
  endtask

  task automatic check_gap(input int k, input int n, input string req);
    int g;
    g = vc[k+1] - dc[k];
    chk(g >= n + 1 && g <= n + 3, req, g, n + 2);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error && !clocks_ready && !wr_valid, "R1 outputs in reset",
        {busy, done, error, clocks_ready, wr_valid}, 0);
    @(negedge clk); rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && !wr_valid && !clocks_ready, "R1 idle after reset",
        {busy, wr_valid, clocks_ready}, 0);
  endtask

  task automatic t_full(input int dly);
    do_reset();
    rd_delay = dly; err_on = -1;
    pulse_start();
    chk(busy && !clocks_ready, "R2 busy after start", busy, 1);
    wait_end();
    @(negedge clk);
    chk(clocks_ready && !busy && !error, "R8 ready level", {clocks_ready, busy, error}, 4);
    chk(done_cnt == 1, "R8 done pulse count", done_cnt, 1);
    chk(nwr == 3, "R7 write count", nwr, 3);
    chk(wa[0] == 8'h01 && wd[0] == 8'h40, "R3 first write", {wa[0], wd[0]}, 16'h0140);
    chk(wa[1] == 8'h01 && wd[1] == 8'h60, "R6 second write", {wa[1], wd[1]}, 16'h0160);
    chk(wa[2] == 8'h04 && wd[2] == 8'h6A, "R7 third write", {wa[2], wd[2]}, 16'h046A);
    check_gap(0, SETTLE, "R5 R12 settle gap");
    check_gap(1, LOCK, "R7 R12 lock gap");
    chk(hold_bad == 0, "R4 handshake hold", hold_bad, 0);
  endtask

  task automatic t_restart_from_ready();
    pulse_start();
    chk(busy && !clocks_ready, "R2 restart from ready", {busy, clocks_ready}, 2);
    wait_end();
    chk(clocks_ready && nwr == 6, "R2 second sequence writes", nwr, 6);
  endtask

  task automatic t_error();
    do_reset();
    rd_delay = 1; err_on = 1;
    pulse_start();
    wait_end();
    @(negedge clk);
    chk(error && !busy && !clocks_ready, "R9 error state", {error, busy, clocks_ready}, 4);
    repeat (60) @(negedge clk);
    chk(error && nwr == 2 && !wr_valid, "R9 no writes after error", nwr, 2);
    err_on = -1;
    pulse_start();
    chk(!error && busy, "R2 restart clears error", {error, busy}, 1);
    wait_end();
    chk(clocks_ready && nwr == 5 && wd[2] == 8'h40, "R2 restart from error", nwr, 5);
  endtask

  task automatic t_busy_start();
    do_reset();
    rd_delay = 0; err_on = -1;
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    wait_end();
    chk(clocks_ready && nwr == 3, "R10 writes with ignored start", nwr, 3);
    check_gap(0, SETTLE, "R10 settle undisturbed");
    check_gap(1, LOCK, "R10 lock undisturbed");
  endtask

  task automatic t_abort();
    do_reset();
    rd_delay = 0; err_on = -1;
    pulse_start();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (nwr == 2) break;
    end
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !error && !clocks_ready && !wr_valid, "R11 idle after abort",
        {busy, error, clocks_ready, wr_valid}, 0);
    repeat (80) @(negedge clk);
    chk(nwr == 0 && !clocks_ready && !busy, "R11 no writes after abort", nwr, 0);
    pulse_start();
    wait_end();
    chk(clocks_ready && nwr == 3, "R2 start after abort", nwr, 3);
  endtask

  initial begin
    bit wd_hit;
    wd_hit = 1'b0;
    fork
      begin
        t_reset();
        t_full(0);
        t_restart_from_ready();
        t_full(3);
        t_error();
        t_busy_start();
        t_abort();
      end
      begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule